// File: doc/BRIEF.md
# DRAM Access and Refresh Sequencer

This block turns simple internal access requests into the strobe timing that an asynchronous DRAM needs for one memory area. A requester presents a byte address, a read/write flag, a size (byte or halfword) and a beat count, and holds `req_valid` until `req_ready` is high on a clock edge. The block puts the row on the multiplexed address bus with the row strobe, then the column with the column strobes. A burst keeps the row open and pulses the column strobes once per successive column (fast page mode). `beat_ack` marks the cycle in which each beat finishes, which is when read data is captured or write data moves on. An external stretch input lengthens any beat.

A refresh timer, loaded from a 10-bit interval setting, raises refresh requests. Each request is served as a column-before-row refresh cycle. A level request puts the DRAM into self-refresh, where both strobes are held low until the request drops. An option adds one precharge cycle after the row strobe rises, so the minimum row precharge time is met before the row strobe falls again.

Top module: `dram_ctl`

## Requirements
- R1: An accepted request (`req_valid` and `req_ready` high at a clock edge) gives one cycle with `row_stb_n` low, `col_stb_n`=2'b11 and `dram_addr` = row = `req_addr[16:9]`. The next cycle has the column `req_addr[8:1]` on `dram_addr` with the column strobes low and `row_stb_n` still low.
- R2: For halfword size (`req_size`=1) both lanes strobe (`col_stb_n`=2'b00). For byte size, `req_addr[0]`=0 gives 2'b10 and `req_addr[0]`=1 gives 2'b01. `wr_en_n` is 0 while the column strobes of a write are low, and 1 for a read.
- R3: A request with `req_len`=N makes N+1 beats with `row_stb_n` held low throughout. Between beats there is exactly one cycle with `col_stb_n`=2'b11. The column advances by one each beat, modulo 256. `beat_ack` is high once per beat.
- R4: With `cfg_pre_en`=1, the cycle after the last beat (or after a refresh) has `row_stb_n`=1 and `req_ready`=0, and the cycle after that is idle. With `cfg_pre_en`=0, `req_ready` is high in the first cycle after the last beat.
- R5: Each cycle in which `stretch_in` is high during a column-strobe cycle repeats that cycle with the same strobes and address, and `beat_ack` stays 0. `beat_ack` is 1 in the cycle when `stretch_in` is low.
- R6: With `cfg_ref_interval`=V, where V is not 0 and V is at least 5, refresh cycles start every V+1 clock cycles. V=0 issues no refresh.
- R7: A refresh cycle is one cycle with `col_stb_n`=2'b00 and `row_stb_n`=1, then one cycle with both strobes low, then both strobes released.
- R8: A refresh that falls due during a burst waits until the burst ends, and the burst is not cut. In the idle cycle that follows, `req_ready` is 0 even if `req_valid` is high, and the refresh cycle starts next.
- R9: While `sr_req` is high, the block runs one cycle with the column strobes low, then holds both strobes low with `sr_ack`=1. `req_ready` is 0 during this time. One cycle after `sr_req` falls, both strobes are released and `sr_ack` is 0.
- R10: After reset `row_stb_n`=1, `col_stb_n`=2'b11, `sr_ack`=0, `beat_ack`=0, and `req_ready`=1 when no refresh or self-refresh is pending.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_addr | input | 17 | Byte address: row, column, lane |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 1 = halfword, 0 = byte |
| req_len | input | 3 | Beats minus one |
| beat_ack | output | 1 | Current beat completes this cycle |
| cfg_pre_en | input | 1 | Insert precharge cycle after row strobe rises |
| cfg_ref_interval | input | 10 | Refresh interval in clocks minus one; 0 disables |
| sr_req | input | 1 | Self-refresh request (level) |
| sr_ack | output | 1 | DRAM held in self-refresh |
| stretch_in | input | 1 | External wait: stretch current beat |
| dram_addr | output | 8 | Multiplexed row/column address |
| row_stb_n | output | 1 | Row address strobe, active low |
| col_stb_n | output | 2 | Column address strobes per byte lane, active low |
| wr_en_n | output | 1 | Write enable, active low |

## Verification
The bench walks bursts whose columns wrap past 255. A design that carried the column into the row, or stopped at the wrap, would show the wrong column on the later beats. It holds the stretch input for several cycles inside a beat, which catches a design that drops the strobes early or acknowledges the beat while stretched. It arranges for a refresh to fall due in the middle of an eight-beat burst and keeps a second request waiting, so a design that cuts the burst or lets the waiting request win over the refresh is caught. It also checks the precharge gap, the strobe order of each refresh cycle, the refresh period, that an interval of zero issues no refresh, and entry into and exit from self-refresh.

// File: rtl/dram_pkg.sv
package dram_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_ROW,
        S_CAS,
        S_CPRE,
        S_PRE,
        S_RCAS,
        S_RRAS,
        S_SCAS,
        S_SREF
    } seq_state_e;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int RI_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RI_W-1:0] cfg_interval,
    input  logic            ref_ack,
    output logic            ref_pend
);
    typedef struct packed {
        logic [RI_W-1:0] cnt;
        logic            pend;
    } tmr_reg_t;

    tmr_reg_t q, d;
    logic     hit;

    always_comb begin
        d   = q;
        hit = (cfg_interval != '0) && (q.cnt >= cfg_interval);
        if (cfg_interval == '0) begin
            d.cnt = '0;
        end else if (hit) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
        d.pend = (q.pend && !ref_ack) || hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ref_pend = q.pend;

    // R6: the counter never runs past a stable interval setting
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_interval != '0 && $stable(cfg_interval)) |-> (q.cnt <= cfg_interval));
endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 8,
    parameter int BLEN_W = 3,
    localparam int ADDR_W = ROW_W + COL_W + 1,
    localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_size,
    input  logic [BLEN_W-1:0] req_len,
    output logic              beat_ack,
    input  logic              cfg_pre_en,
    input  logic              ref_pend,
    output logic              ref_ack,
    input  logic              sr_req,
    output logic              sr_ack,
    input  logic              stretch_in,
    output logic [MA_W-1:0]   dram_addr,
    output logic              row_stb_n,
    output logic [1:0]        col_stb_n,
    output logic              wr_en_n
);
    typedef struct packed {
        seq_state_e        st;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [1:0]        lane;
        logic              wr;
        logic [BLEN_W-1:0] left;
    } seq_reg_t;

    seq_reg_t   q, d;
    seq_state_e after_row;

    always_comb begin
        d         = q;
        ref_ack   = 1'b0;
        beat_ack  = 1'b0;
        after_row = cfg_pre_en ? S_PRE : S_IDLE;
        unique case (q.st)
            S_IDLE: begin
                if (ref_pend) begin
                    d.st    = S_RCAS;
                    ref_ack = 1'b1;
                end else if (sr_req) begin
                    d.st = S_SCAS;
                end else if (req_valid) begin
                    d.st   = S_ROW;
                    d.row  = req_addr[ADDR_W-1:COL_W+1];
                    d.col  = req_addr[COL_W:1];
                    d.lane = req_size ? 2'b11 : (req_addr[0] ? 2'b10 : 2'b01);
                    d.wr   = req_write;
                    d.left = req_len;
                end
            end
            S_ROW:  d.st = S_CAS;
            S_CAS: begin
                if (!stretch_in) begin
                    beat_ack = 1'b1;
                    if (q.left != '0) begin
                        d.left = q.left - 1'b1;
                        d.col  = q.col + 1'b1;
                        d.st   = S_CPRE;
                    end else begin
                        d.st = after_row;
                    end
                end
            end
            S_CPRE: d.st = S_CAS;
            S_PRE:  d.st = S_IDLE;
            S_RCAS: d.st = S_RRAS;
            S_RRAS: d.st = after_row;
            S_SCAS: d.st = S_SREF;
            S_SREF: if (!sr_req) d.st = after_row;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= S_IDLE;
            q.row  <= '0;
            q.col  <= '0;
            q.lane <= '0;
            q.wr   <= 1'b0;
            q.left <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        row_stb_n = !(q.st inside {S_ROW, S_CAS, S_CPRE, S_RRAS, S_SREF});
        if (q.st == S_CAS) begin
            col_stb_n = ~q.lane;
        end else if (q.st inside {S_RCAS, S_RRAS, S_SCAS, S_SREF}) begin
            col_stb_n = 2'b00;
        end else begin
            col_stb_n = 2'b11;
        end
        dram_addr = (q.st == S_ROW) ? MA_W'(q.row) : MA_W'(q.col);
        wr_en_n   = !(q.wr && (q.st inside {S_CAS, S_CPRE}));
        req_ready = (q.st == S_IDLE) && !ref_pend && !sr_req;
        sr_ack    = (q.st == S_SREF);
    end

    // R5: a stretched beat keeps strobes and address unchanged
    a_r5_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_CAS && stretch_in) |=> ($stable(col_stb_n) && $stable(dram_addr) && !row_stb_n));
    // R3: between burst beats the row stays open
    a_r3_page_row_open: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ack && q.left != '0) |=> (!row_stb_n && col_stb_n == 2'b11));
    // R7: if the row strobe falls with column strobes low, they were already low
    a_r7_cbr_order: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(row_stb_n) && col_stb_n != 2'b11) |-> ($past(col_stb_n) == 2'b00));
    // R4: precharge cycle keeps the row strobe high and blocks requests
    a_r4_pre_block: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(row_stb_n) && $past(cfg_pre_en)) |-> !req_ready);
    a_r4_pre_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(row_stb_n) && $past(cfg_pre_en)) |=> row_stb_n);
    // R8: an idle cycle with a pending refresh starts a refresh cycle
    a_r8_ref_first: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && ref_pend) |=> (col_stb_n == 2'b00 && row_stb_n));
    // R9: self-refresh is held while requested
    a_r9_sr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_ack && sr_req) |=> sr_ack);
endmodule

// File: rtl/dram_ctl.sv
module dram_ctl #(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 8,
    parameter int BLEN_W = 3,
    parameter int RI_W   = 10,
    localparam int ADDR_W = ROW_W + COL_W + 1,
    localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_size,
    input  logic [BLEN_W-1:0] req_len,
    output logic              beat_ack,
    input  logic              cfg_pre_en,
    input  logic [RI_W-1:0]   cfg_ref_interval,
    input  logic              sr_req,
    output logic              sr_ack,
    input  logic              stretch_in,
    output logic [MA_W-1:0]   dram_addr,
    output logic              row_stb_n,
    output logic [1:0]        col_stb_n,
    output logic              wr_en_n
);
    logic ref_pend;
    logic ref_ack;

    dram_refresh_timer #(.RI_W(RI_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_interval (cfg_ref_interval),
        .ref_ack      (ref_ack),
        .ref_pend     (ref_pend)
    );

    dram_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .BLEN_W(BLEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_len    (req_len),
        .beat_ack   (beat_ack),
        .cfg_pre_en (cfg_pre_en),
        .ref_pend   (ref_pend),
        .ref_ack    (ref_ack),
        .sr_req     (sr_req),
        .sr_ack     (sr_ack),
        .stretch_in (stretch_in),
        .dram_addr  (dram_addr),
        .row_stb_n  (row_stb_n),
        .col_stb_n  (col_stb_n),
        .wr_en_n    (wr_en_n)
    );
endmodule

// File: tb/dram_ctl_tb_top.sv
`timescale 1ns/1ps
module dram_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [16:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_size = 1'b0;
    logic [2:0]  req_len = '0;
    logic        beat_ack;
    logic        cfg_pre_en = 1'b0;
    logic [9:0]  cfg_ref_interval = '0;
    logic        sr_req = 1'b0;
    logic        sr_ack;
    logic        stretch_in = 1'b0;
    logic [7:0]  dram_addr;
    logic        row_stb_n;
    logic [1:0]  col_stb_n;
    logic        wr_en_n;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    dram_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
        .req_len(req_len), .beat_ack(beat_ack), .cfg_pre_en(cfg_pre_en),
        .cfg_ref_interval(cfg_ref_interval), .sr_req(sr_req), .sr_ack(sr_ack),
        .stretch_in(stretch_in), .dram_addr(dram_addr), .row_stb_n(row_stb_n),
        .col_stb_n(col_stb_n), .wr_en_n(wr_en_n)
    );

    typedef struct packed {
        logic [7:0] row;
        logic [7:0] col;
        logic       lane;
        logic       wr;
        logic       sz;
        logic [2:0] len;
        logic [1:0] waits;
        logic       pre;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{row: 8'h12, col: 8'h34, lane: 1'b0, wr: 1'b0, sz: 1'b1, len: 3'd0, waits: 2'd0, pre: 1'b0},
        '{row: 8'hA5, col: 8'h0F, lane: 1'b1, wr: 1'b1, sz: 1'b0, len: 3'd0, waits: 2'd2, pre: 1'b1},
        '{row: 8'h3C, col: 8'hFE, lane: 1'b0, wr: 1'b0, sz: 1'b1, len: 3'd3, waits: 2'd0, pre: 1'b0},
        '{row: 8'hFF, col: 8'h80, lane: 1'b0, wr: 1'b1, sz: 1'b1, len: 3'd2, waits: 2'd1, pre: 1'b1},
        '{row: 8'h00, col: 8'h00, lane: 1'b0, wr: 1'b0, sz: 1'b0, len: 3'd7, waits: 2'd0, pre: 1'b1},
        '{row: 8'h5A, col: 8'hFF, lane: 1'b1, wr: 1'b1, sz: 1'b0, len: 3'd1, waits: 2'd3, pre: 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [1:0] lane_n;
        lane_n = v.sz ? 2'b00 : (v.lane ? 2'b01 : 2'b10);
        cfg_pre_en = v.pre;
        @(negedge clk);
        chk("R1 ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_addr  = {v.row, v.col, v.lane};
        req_write = v.wr;
        req_size  = v.sz;
        req_len   = v.len;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 row phase", {21'd0, row_stb_n, col_stb_n, dram_addr}, {21'd0, 1'b0, 2'b11, v.row});
        for (int b = 0; b <= int'(v.len); b++) begin
            @(negedge clk);
            chk("R1 R2 R3 column phase", {20'd0, row_stb_n, col_stb_n, wr_en_n, dram_addr},
                {20'd0, 1'b0, lane_n, ~v.wr, 8'(v.col + 8'(b))});
            for (int w = 0; w < int'(v.waits); w++) begin
                stretch_in = 1'b1;
                #1;
                chk("R5 no ack while stretched", {31'd0, beat_ack}, 32'd0);
                @(negedge clk);
                chk("R5 stretched beat held", {22'd0, row_stb_n, col_stb_n, dram_addr},
                    {22'd0, 1'b0, lane_n, 8'(v.col + 8'(b))});
            end
            stretch_in = 1'b0;
            #1;
            chk("R3 R5 beat ack", {31'd0, beat_ack}, 32'd1);
            if (b < int'(v.len)) begin
                @(negedge clk);
                chk("R3 page gap", {29'd0, row_stb_n, col_stb_n}, {29'd0, 1'b0, 2'b11});
            end
        end
        @(negedge clk);
        chk("R4 release after access", {30'd0, row_stb_n, req_ready}, {30'd0, 1'b1, ~v.pre});
        if (v.pre) begin
            @(negedge clk);
            chk("R4 ready after precharge", {31'd0, req_ready}, 32'd1);
        end
    endtask

    logic       rs [80];
    logic [1:0] cs [80];

    initial begin
        int starts [3];
        int ns;
        int ln;
        int falls;
        logic [1:0] pc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset strobes", {27'd0, row_stb_n, col_stb_n, sr_ack, beat_ack}, {27'd0, 1'b1, 2'b11, 1'b0, 1'b0});
        chk("R10 reset ready", {31'd0, req_ready}, 32'd1);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R6 and R7: refresh period and order
        cfg_pre_en = 1'b0;
        cfg_ref_interval = 10'd20;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            rs[i] = row_stb_n;
            cs[i] = col_stb_n;
        end
        ns = 0;
        for (int i = 0; i < 80; i++) begin
            if (cs[i] == 2'b00 && rs[i] == 1'b1 && ns < 3) begin
                starts[ns] = i;
                ns++;
            end
        end
        chk("R6 refresh count", ns, 3);
        if (ns == 3) begin
            chk("R6 refresh period 1", starts[1] - starts[0], 21);
            chk("R6 refresh period 2", starts[2] - starts[1], 21);
            chk("R7 both strobes low", {30'd0, rs[starts[0]+1], cs[starts[0]+1]}, 32'd0);
            chk("R7 strobes released", {29'd0, rs[starts[0]+2], cs[starts[0]+2]}, {29'd0, 1'b1, 2'b11});
        end

        // R8: refresh due mid-burst waits, and beats a waiting request
        cfg_ref_interval = 10'd12;
        ln = 0;
        while (!(col_stb_n == 2'b00 && row_stb_n == 1'b1) && ln < 40) begin
            @(negedge clk);
            ln++;
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {8'h11, 8'h20, 1'b0};
        req_write = 1'b0;
        req_size  = 1'b1;
        req_len   = 3'd7;
        @(negedge clk);
        chk("R8 idle before burst", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        ln = 0;
        falls = 0;
        pc = 2'b11;
        while (row_stb_n == 1'b0 && ln < 40) begin
            ln++;
            if (col_stb_n != 2'b11 && pc == 2'b11) falls++;
            pc = col_stb_n;
            @(negedge clk);
        end
        chk("R8 burst row held", ln, 16);
        chk("R8 burst beats", falls, 8);
        chk("R8 request blocked by refresh", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        chk("R8 refresh first", {29'd0, row_stb_n, col_stb_n}, {29'd0, 1'b1, 2'b00});
        req_valid = 1'b0;
        cfg_ref_interval = 10'd0;
        repeat (30) @(negedge clk);

        // R6: interval zero issues no refresh
        ln = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (col_stb_n != 2'b11 || row_stb_n == 1'b0) ln++;
        end
        chk("R6 disabled refresh", ln, 0);

        // R9: self-refresh entry, hold, exit
        cfg_pre_en = 1'b1;
        sr_req = 1'b1;
        req_valid = 1'b1;
        req_len = 3'd0;
        @(negedge clk);
        chk("R9 entry column first", {29'd0, row_stb_n, col_stb_n}, {29'd0, 1'b1, 2'b00});
        @(negedge clk);
        chk("R9 held state", {28'd0, row_stb_n, col_stb_n, sr_ack, req_ready}, {28'd0, 1'b0, 2'b00, 1'b1, 1'b0});
        ln = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (row_stb_n != 1'b0 || col_stb_n != 2'b00 || sr_ack != 1'b1 || req_ready != 1'b0) ln++;
        end
        chk("R9 hold steady", ln, 0);
        sr_req = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9 exit release", {28'd0, row_stb_n, col_stb_n, sr_ack}, {28'd0, 1'b1, 2'b11, 1'b0});
        chk("R4 precharge after self-refresh", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        chk("R9 ready after exit", {31'd0, req_ready}, 32'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule